// File: doc/BRIEF.md
# CPU-to-PCI Single Read Initiator

This block lets a local processor read one 32-bit word from a PCI target. The bridge acts as the PCI bus master. A processor read starts when the address strobe is sampled together with the internal decode hit. The bridge then waits behind any posted write that has not yet drained, and spends one clock synchronising the request. After that it raises its bus request and waits for a grant on a clock when no other master is using the bus. It then runs one address phase and one data phase.

The processor always gets the non-burst ready. A burst request is therefore answered one word at a time, and the processor repeats it as single cycles. On the PCI side the block handles target wait states, target retry (re-arbitrate and repeat the same read) and master abort when no target claims the access. A master abort returns all-ones data.

Both sides run on one clock. PCI control levels on the ports are active-high; the pad logic inverts them. The shared AD bus is split into a drive value, a drive enable and a sampled input.

Top module: `pci_rd_bridge`

## Requirements
- R1: A read is accepted only on a clock where `cpu_ads_i` and `cpu_hit_i` are both high. A strobe without the hit produces no bus request and no ready.
- R2: Every accepted read ends with `cpu_rdy_o` high for exactly one clock, even when `cpu_last_i` is low (burst request). `cpu_brdy_o` is never asserted.
- R3: While `wb_pend_i` is high after acceptance, `pci_req_o` and `pci_frame_o` stay low.
- R4: `pci_req_o` rises one clock after the synchronising clock that follows acceptance, provided no write is pending. It stays high until the address phase.
- R5: `pci_frame_o` rises only after a clock on which `pci_gnt_i` was high and both `bus_frame_i` and `bus_irdy_i` were low.
- R6: The address phase lasts one clock. In it, `pci_ad_oe_o` is high, `pci_ad_o` carries the address and `pci_cbe_o` = 4'b0110 (memory read). On the next clock FRAME is low, IRDY is high, AD is released and `pci_cbe_o` = ~`cpu_be_i` (byte enables active-high at the CPU port, active-low on the bus).
- R7: Data is taken from `pci_ad_i` on the clock where `pci_trdy_i` and `pci_devsel_i` are both high with IRDY. It reaches `cpu_data_o` with the ready pulse on the following clock. Up to 16 target wait states are tolerated.
- R8: STOP without TRDY in the data phase ends the attempt. IRDY is released and the bridge requests the bus again, then repeats the read with the same address. The processor sees a ready only after data has moved.
- R9: If DEVSEL has not been high during the first 5 data-phase clocks, the bridge ends the transaction and returns 32'hFFFF_FFFF with the ready.
- R10: During and right after reset, every output control (request, FRAME, IRDY, AD and C/BE enables, both readies) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared CPU/PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ads_i | input | 1 | Processor address strobe |
| cpu_hit_i | input | 1 | Address decode says the access is on PCI |
| cpu_addr_i | input | 32 | Read address |
| cpu_be_i | input | 4 | Byte enables, active-high |
| cpu_last_i | input | 1 | High for a single transfer, low for a burst request |
| cpu_data_o | output | 32 | Read data |
| cpu_rdy_o | output | 1 | Non-burst ready |
| cpu_brdy_o | output | 1 | Burst ready, always low |
| wb_pend_i | input | 1 | Posted write still in the write buffer |
| pci_req_o | output | 1 | Bus request to the arbiter |
| pci_gnt_i | input | 1 | Grant from the arbiter |
| pci_frame_o | output | 1 | FRAME driven by this master |
| pci_irdy_o | output | 1 | IRDY driven by this master |
| bus_frame_i | input | 1 | FRAME driven by another master |
| bus_irdy_i | input | 1 | IRDY driven by another master |
| pci_trdy_i | input | 1 | Target ready |
| pci_devsel_i | input | 1 | Target claims the access |
| pci_stop_i | input | 1 | Target stop |
| pci_ad_o | output | 32 | AD drive value |
| pci_ad_oe_o | output | 1 | AD drive enable |
| pci_ad_i | input | 32 | Sampled AD bus |
| pci_cbe_o | output | 4 | Command or byte enables, active-low |
| pci_cbe_oe_o | output | 1 | C/BE drive enable |

## Verification
The embedded assertions check the following on every clock:
- FRAME rises only after a sampled grant on an idle bus.
- FRAME lasts one clock and hands over to IRDY.
- AD is never driven while IRDY is high.
- The request never rises while a posted write was pending.
- A retry is followed by a fresh request.
- The ready is a single-clock pulse.
- The DEVSEL timeout counter stays in range.

Other behaviour only the bench scenarios can show. These include the returned data values and the byte-enable encoding on the bus. They also include that the retry count matches the number of address phases, with the same address each time. Finally, they cover the all-ones result of an absent target and the silence after a strobe without the decode hit.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

    localparam int ADDR_W      = 32;
    localparam int BE_W        = ADDR_W / 8;
    localparam int DEVSEL_TMO  = 5;
    localparam logic [BE_W-1:0] CMD_MEM_READ = 4'b0110;
    localparam logic [ADDR_W-1:0] ABORT_DATA = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ARB,
        ST_ADDR,
        ST_DATA
    } mst_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic              last;
    } rd_req_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] data;
    } rd_fin_t;

    function automatic logic [BE_W-1:0] be_to_bus(input logic [BE_W-1:0] be);
        return ~be;
    endfunction

    function automatic logic bus_free(input logic f, input logic i);
        return !f && !i;
    endfunction

endpackage

// File: rtl/rd_cpu_port.sv
module rd_cpu_port
    import pci_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_i,
    input  logic              hit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              last_i,
    input  rd_fin_t           fin_i,
    output logic              start_o,
    output rd_req_t           req_o,
    output logic              rdy_o,
    output logic [ADDR_W-1:0] data_o
);

    logic    pend_q;
    rd_req_t req_q;
    logic    take;

    assign take    = ads_i && hit_i && !pend_q;
    assign start_o = take;
    assign req_o   = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            req_q  <= '0;
            rdy_o  <= 1'b0;
            data_o <= '0;
        end else begin
            rdy_o <= fin_i.valid;
            if (fin_i.valid) begin
                data_o <= fin_i.data;
            end
            if (take) begin
                pend_q     <= 1'b1;
                req_q.addr <= addr_i;
                req_q.be   <= be_i;
                req_q.last <= last_i;
            end else if (fin_i.valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R2: a burst request is still answered with one single ready
    a_r2_burst_one_ready: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && !req_q.last) |=> !rdy_o);

    // R2: the ready is never longer than one clock
    a_r2_rdy_single: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);

    // R1: the captured request is held while the read is outstanding
    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !fin_i.valid) |=> $stable(req_q));

endmodule

// File: rtl/rd_devsel_watch.sv
module rd_devsel_watch #(
    parameter int TMO = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic devsel_i,
    output logic expire_o
);

    localparam int CW = $clog2(TMO + 1);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    assign expire_o = active_i && !seen_q && !devsel_i &&
                      (cnt_q == CW'(TMO - 1));

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (devsel_i) begin
            seen_q <= 1'b1;
        end else if (!seen_q && !expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the silent-clock count never passes the timeout
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(TMO));

    // R9: once claimed, no timeout may fire in the same data phase
    a_r9_no_expire_after_claim: assert property (@(posedge clk) disable iff (rst)
        (active_i && devsel_i) |=> !(active_i && expire_o));

endmodule

// File: rtl/rd_pci_master.sv
module rd_pci_master
    import pci_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  rd_req_t           req_i,
    input  logic              wb_pend_i,
    input  logic              gnt_i,
    input  logic              bus_frame_i,
    input  logic              bus_irdy_i,
    input  logic              trdy_i,
    input  logic              devsel_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic              expire_i,
    output logic              data_act_o,
    output rd_fin_t           fin_o,
    output logic              req_o,
    output logic              frame_o,
    output logic              irdy_o,
    output logic [ADDR_W-1:0] ad_o,
    output logic              ad_oe_o,
    output logic [BE_W-1:0]   cbe_o,
    output logic              cbe_oe_o
);

    mst_e state_q, state_d;
    logic got_data, got_retry;

    assign got_data  = (state_q == ST_DATA) && trdy_i && devsel_i;
    assign got_retry = (state_q == ST_DATA) && stop_i && !trdy_i;

    always_comb begin
        state_d = state_q;
        fin_o   = '0;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SYNC;
            ST_SYNC: if (!wb_pend_i) state_d = ST_ARB;
            ST_ARB:  if (gnt_i && bus_free(bus_frame_i, bus_irdy_i)) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (got_data) begin
                    state_d    = ST_IDLE;
                    fin_o.valid = 1'b1;
                    fin_o.data  = ad_i;
                end else if (got_retry) begin
                    state_d = ST_ARB;
                end else if (expire_i) begin
                    state_d    = ST_IDLE;
                    fin_o.valid = 1'b1;
                    fin_o.data  = ABORT_DATA;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign data_act_o = (state_q == ST_DATA);
    assign req_o      = (state_q == ST_ARB);
    assign frame_o    = (state_q == ST_ADDR);
    assign irdy_o     = (state_q == ST_DATA);
    assign ad_oe_o    = (state_q == ST_ADDR);
    assign ad_o       = req_i.addr;
    assign cbe_oe_o   = (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign cbe_o      = (state_q == ST_ADDR) ? CMD_MEM_READ : be_to_bus(req_i.be);

    // R5: FRAME starts only after a sampled grant on an idle bus
    a_r5_frame_after_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_o) |-> $past(gnt_i && !bus_frame_i && !bus_irdy_i));

    // R6: single data phase, FRAME hands over to IRDY
    a_r6_frame_to_irdy: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> (irdy_o && !frame_o));

    // R6: AD released during the data phase (turnaround)
    a_r6_ad_turnaround: assert property (@(posedge clk) disable iff (rst)
        irdy_o |-> !ad_oe_o);

    // R6: command code on C/BE during the address phase
    a_r6_cmd_code: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> (cbe_oe_o && cbe_o == CMD_MEM_READ));

    // R3: no request is raised while a posted write was pending
    a_r3_wait_write: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(!wb_pend_i || state_q == ST_DATA));

    // R8: a retry releases IRDY and asks for the bus again
    a_r8_retry_rearb: assert property (@(posedge clk) disable iff (rst)
        (irdy_o && stop_i && !trdy_i) |=> (req_o && !irdy_o));

endmodule

// File: rtl/pci_rd_bridge.sv
module pci_rd_bridge
    import pci_rd_pkg::*;
#(
    parameter int DEVSEL_CLKS = DEVSEL_TMO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ads_i,
    input  logic              cpu_hit_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [BE_W-1:0]   cpu_be_i,
    input  logic              cpu_last_i,
    output logic [ADDR_W-1:0] cpu_data_o,
    output logic              cpu_rdy_o,
    output logic              cpu_brdy_o,
    input  logic              wb_pend_i,
    output logic              pci_req_o,
    input  logic              pci_gnt_i,
    output logic              pci_frame_o,
    output logic              pci_irdy_o,
    input  logic              bus_frame_i,
    input  logic              bus_irdy_i,
    input  logic              pci_trdy_i,
    input  logic              pci_devsel_i,
    input  logic              pci_stop_i,
    output logic [ADDR_W-1:0] pci_ad_o,
    output logic              pci_ad_oe_o,
    input  logic [ADDR_W-1:0] pci_ad_i,
    output logic [BE_W-1:0]   pci_cbe_o,
    output logic              pci_cbe_oe_o
);

    logic    start;
    rd_req_t req;
    rd_fin_t fin;
    logic    data_act;
    logic    expire;

    assign cpu_brdy_o = 1'b0;

    rd_cpu_port u_cpu (
        .clk     (clk),
        .rst     (rst),
        .ads_i   (cpu_ads_i),
        .hit_i   (cpu_hit_i),
        .addr_i  (cpu_addr_i),
        .be_i    (cpu_be_i),
        .last_i  (cpu_last_i),
        .fin_i   (fin),
        .start_o (start),
        .req_o   (req),
        .rdy_o   (cpu_rdy_o),
        .data_o  (cpu_data_o)
    );

    rd_devsel_watch #(.TMO(DEVSEL_CLKS)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .active_i (data_act),
        .devsel_i (pci_devsel_i),
        .expire_o (expire)
    );

    rd_pci_master u_mst (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .req_i       (req),
        .wb_pend_i   (wb_pend_i),
        .gnt_i       (pci_gnt_i),
        .bus_frame_i (bus_frame_i),
        .bus_irdy_i  (bus_irdy_i),
        .trdy_i      (pci_trdy_i),
        .devsel_i    (pci_devsel_i),
        .stop_i      (pci_stop_i),
        .ad_i        (pci_ad_i),
        .expire_i    (expire),
        .data_act_o  (data_act),
        .fin_o       (fin),
        .req_o       (pci_req_o),
        .frame_o     (pci_frame_o),
        .irdy_o      (pci_irdy_o),
        .ad_o        (pci_ad_o),
        .ad_oe_o     (pci_ad_oe_o),
        .cbe_o       (pci_cbe_o),
        .cbe_oe_o    (pci_cbe_oe_o)
    );

    // R10: all controls quiet in the clock after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(pci_req_o || pci_frame_o || pci_irdy_o ||
                         pci_ad_oe_o || pci_cbe_oe_o || cpu_rdy_o));

endmodule

// File: tb/sim_pci_rd_bridge.sv
module sim_pci_rd_bridge;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        ads = 0, hit = 0, last = 1, wb = 0, gnt = 0;
    logic        bfr = 0, birdy = 0, trdy = 0, devsel = 0, stop = 0;
    logic [31:0] addr = 0, ad_in = 0;
    logic [3:0]  be = 0;
    logic [31:0] cpu_data, ad_out;
    logic        cpu_rdy, cpu_brdy, req, frame, irdy, ad_oe, cbe_oe;
    logic [3:0]  cbe;

    pci_rd_bridge u0 (
        .clk(clk), .rst(rst), .cpu_ads_i(ads), .cpu_hit_i(hit),
        .cpu_addr_i(addr), .cpu_be_i(be), .cpu_last_i(last),
        .cpu_data_o(cpu_data), .cpu_rdy_o(cpu_rdy), .cpu_brdy_o(cpu_brdy),
        .wb_pend_i(wb), .pci_req_o(req), .pci_gnt_i(gnt),
        .pci_frame_o(frame), .pci_irdy_o(irdy), .bus_frame_i(bfr),
        .bus_irdy_i(birdy), .pci_trdy_i(trdy), .pci_devsel_i(devsel),
        .pci_stop_i(stop), .pci_ad_o(ad_out), .pci_ad_oe_o(ad_oe),
        .pci_ad_i(ad_in), .pci_cbe_o(cbe), .pci_cbe_oe_o(cbe_oe)
    );

    int checks = 0, errors = 0;

    // target / arbiter configuration
    int t_ws = 0, t_dsel = 0, t_retry = 0, t_absent = 0, tk = 0, g_dly = 0, gcnt = 0;
    bit park = 1, was_retry = 0;
    logic [31:0] exp_addr = 0;
    // monitor results
    int frames = 0, frame_bad = 0, addr_bad = 0, ta_bad = 0, brdy_seen = 0, rdy_cnt = 0;
    logic [3:0] last_cbe = 0;
    logic frame_q = 0, gnt_s = 0, busy_s = 0;

    function automatic logic [31:0] data_of(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    always @(posedge clk) begin
        gnt_s  <= gnt;
        busy_s <= bfr | birdy;
    end

    always @(negedge clk) begin
        if (rst) begin
            trdy = 0; devsel = 0; stop = 0; tk = 0; frame_q = 0;
        end else begin
            if (frame && !frame_q) begin
                frames++;
                if (!gnt_s || busy_s) frame_bad++;
                if (!(ad_oe && ad_out == exp_addr && cbe == 4'b0110)) addr_bad++;
            end
            frame_q = frame;
            if (irdy) begin
                last_cbe = cbe;
                if (ad_oe) ta_bad++;
            end
            if (cpu_brdy) brdy_seen++;
            if (cpu_rdy) rdy_cnt++;
            if (irdy) begin
                if (t_absent == 0) begin
                    devsel = (tk >= t_dsel);
                    if (t_retry > 0 && tk >= t_dsel) begin
                        stop = 1; trdy = 0; was_retry = 1;
                    end else begin
                        stop = 0; trdy = (tk >= t_ws); ad_in = data_of(exp_addr);
                    end
                end
                tk++;
            end else begin
                trdy = 0; devsel = 0; stop = 0; tk = 0;
                if (was_retry) begin t_retry--; was_retry = 0; end
            end
            if (park) gnt = 1;
            else begin
                if (req) gcnt++; else gcnt = 0;
                gnt = req && (gcnt > g_dly);
            end
        end
    end

    task automatic launch(input logic [31:0] a, input logic [3:0] b, input bit bl);
        exp_addr = a; frames = 0; rdy_cnt = 0;
        ads = 1; hit = 1; addr = a; be = b; last = bl;
        tick();
        ads = 0; hit = 0; addr = $urandom; be = 4'($urandom);
    endtask

    task automatic finish_rd(input logic [3:0] b, input int nretry, input bit absent);
        int n = 0;
        logic [31:0] exp;
        while (!cpu_rdy && n < 400) begin tick(); n++; end
        exp = absent ? 32'hFFFF_FFFF : data_of(exp_addr);
        chk(cpu_rdy == 1'b1, "R7 ready returned", 32'(cpu_rdy), 1);
        chk(cpu_data == exp, absent ? "R9 abort data" : "R7 read data", cpu_data, exp);
        tick();
        chk(cpu_rdy == 1'b0 && rdy_cnt == 1, "R2 single ready pulse", 32'(rdy_cnt), 1);
        chk(frames == nretry + 1, "R8 address phase count", 32'(frames), 32'(nretry + 1));
        chk(addr_bad == 0, "R6 address phase AD/CBE", 32'(addr_bad), 0);
        chk(last_cbe == ~b, "R6 data phase byte enables", 32'(last_cbe), 32'(~b));
        chk(ta_bad == 0, "R6 AD turnaround", 32'(ta_bad), 0);
        chk(frame_bad == 0, "R5 frame needs grant and idle bus", 32'(frame_bad), 0);
    endtask

    task automatic cfg(input int ws, input int nr, input int ab, input bit pk, input int gd);
        t_ws = ws; t_dsel = (ws < 2) ? ws : 2; t_retry = nr; t_absent = ab;
        park = pk; g_dly = gd;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", wd);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst = 0;
        tick();
        // R10 reset state
        chk({req, frame, irdy, ad_oe, cbe_oe, cpu_rdy, cpu_brdy} == 7'b0, "R10 reset outputs",
            32'({req, frame, irdy, ad_oe, cbe_oe, cpu_rdy, cpu_brdy}), 0);

        // R1 strobe without decode hit
        cfg(0, 0, 0, 1, 0);
        ads = 1; hit = 0; addr = 32'h1000_0000; tick(); ads = 0;
        begin
            int seen = 0;
            repeat (12) begin tick(); if (req || frame || cpu_rdy) seen++; end
            chk(seen == 0, "R1 no-hit strobe ignored", 32'(seen), 0);
        end

        // R1/R7 plain read with parked grant
        cfg(0, 0, 0, 1, 0);
        launch(32'h2000_0010, 4'b1111, 1);
        finish_rd(4'b1111, 0, 0);

        // R3 posted write pending, R4 request timing
        cfg(1, 0, 0, 0, 2);
        wb = 1;
        launch(32'h3000_0040, 4'b0011, 1);
        begin
            int bad = 0;
            repeat (10) begin tick(); if (req || frame) bad++; end
            chk(bad == 0, "R3 stall behind posted write", 32'(bad), 0);
        end
        wb = 0;
        tick();
        chk(req == 1'b1 && frame == 1'b0, "R4 request after write drains", 32'({req, frame}), 2);
        finish_rd(4'b0011, 0, 0);

        // R4 request one clock after sync, held until grant
        cfg(0, 0, 0, 0, 3);
        launch(32'h3100_0080, 4'b1100, 1);
        chk(req == 1'b0, "R4 sync clock before request", 32'(req), 0);
        tick();
        chk(req == 1'b1, "R4 request raised", 32'(req), 1);
        tick(); tick();
        chk(req == 1'b1 && frame == 1'b0, "R4 request held without grant", 32'({req, frame}), 2);
        finish_rd(4'b1100, 0, 0);

        // R5 bus busy with grant parked
        cfg(0, 0, 0, 1, 0);
        bfr = 1;
        launch(32'h4000_0004, 4'b0001, 1);
        begin
            int bad = 0;
            repeat (6) begin tick(); if (frame) bad++; end
            chk(bad == 0, "R5 no frame while bus busy", 32'(bad), 0);
        end
        bfr = 0; birdy = 1; tick(); tick();
        chk(frame == 1'b0, "R5 no frame while other irdy", 32'(frame), 0);
        birdy = 0;
        finish_rd(4'b0001, 0, 0);

        // R7 sixteen wait states, burst request (R2)
        cfg(16, 0, 0, 1, 0);
        launch(32'h5000_0100, 4'b1010, 0);
        finish_rd(4'b1010, 0, 0);

        // R8 two retries
        cfg(2, 2, 0, 0, 1);
        launch(32'h6000_0200, 4'b0110, 1);
        finish_rd(4'b0110, 2, 0);

        // R9 absent target
        cfg(0, 0, 1, 1, 0);
        launch(32'h7000_0300, 4'b1111, 1);
        finish_rd(4'b1111, 0, 1);

        // random mix
        for (int i = 0; i < 25; i++) begin
            int ws = $urandom % 17;
            int nr = $urandom % 3;
            int ab = (($urandom % 8) == 0) ? 1 : 0;
            bit pk = $urandom % 2;
            logic [3:0] b = 4'($urandom % 15 + 1);
            logic [31:0] a = {$urandom} & 32'hFFFF_FFFC;
            if (ab != 0) nr = 0;
            cfg(ws, nr, ab, pk, $urandom % 4);
            launch(a, b, 1'($urandom % 2));
            finish_rd(b, nr, ab != 0);
        end

        chk(brdy_seen == 0, "R2 burst ready never asserted", 32'(brdy_seen), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule